// File: doc/BRIEF.md
# RTC Alarm and Interrupt Controller

This block is the interrupt half of a PC-style real-time clock. It keeps a BCD time of day (seconds, minutes, hours) and a date (day of month, month). A one-second tick input advances this time. The block also holds a matching set of alarm registers, a control register, a periodic-rate register and an interrupt-flag register. A host reaches all of them through a simple strobed register port. There are three interrupt sources: a periodic event derived from a fast reference tick, an alarm match, and an update event that fires after each advance of the time. Each source latches a flag, and the active-high level output `irq` follows the master flag.

A small sequencer handles every one-second tick. It has three states and three transitions:
- `ST_IDLE` goes to `ST_ADVANCE` when `sec_tick` is sampled high.
- `ST_ADVANCE` always goes to `ST_MATCH`. In `ST_ADVANCE` the time counters step once.
- `ST_MATCH` always goes back to `ST_IDLE`. In `ST_MATCH` the update flag is set, and the alarm flag is set if the alarm compare hits.

A tick that arrives while the sequencer is not in `ST_IDLE` is dropped. A host write to a time register in the same cycle as `ST_ADVANCE` takes priority, and the advance is skipped. Only 24-hour BCD operation exists.

Register addresses (4-bit): 0 seconds, 1 minutes, 2 hours, 3 day, 4 month, 5 alarm seconds, 6 alarm minutes, 7 alarm hours, 8 alarm day, 9 alarm month, 10 rate, 11 control, 12 flags. Any other address reads 0.

Top module: `rtc_irq_ctrl`

## Requirements
- R1: After reset the time reads 00:00:00 with day 0x01 and month 0x01. All alarm registers read 0x00. The rate register reads 0x06. The control register reads 0x02. The flags read 0x00 and `irq` is low.
- R2: Time, alarm and rate registers read back what was written. The rate register keeps only its low 4 bits. Read data appears on `rdata` the cycle after `rd_en` is sampled.
- R3: Control bits 6, 5 and 4 are the periodic, alarm and update enables. Bit 1 (24-hour mode) always reads 1. Bit 2 (binary mode) always reads 0. All other control bits read 0, whatever is written.
- R4: Each accepted one-second tick advances the time in BCD. Seconds wrap from 0x59 to 0x00 with a carry into minutes. Minutes do the same into hours. Hours wrap from 0x23 to 0x00 with a carry into the day. The day wraps from 0x31 to 0x01 with a carry into the month. The month wraps from 0x12 to 0x01.
- R5: Flag bit 4 (update) sets on every accepted tick, after the time has advanced, whether or not its enable is set.
- R6: Flag bit 5 (alarm) sets once, right after a tick, when every alarm field that is not a don't-care equals its time field. A value of 0xFF in alarm seconds, minutes or hours is a don't-care.
- R7: The day alarm compares only its low six bits, and a low-six-bit value of 0 is a don't-care. The month alarm treats 0x00 and 0xFF as don't-care.
- R8: With a rate value f from 1 to 15, flag bit 6 (periodic) sets on every 2^(f-1)-th reference tick, counted from the last write of the rate register. A rate of 0 gives no periodic events.
- R9: Flags latch even when their enable is clear. Flag bit 7 (master) and `irq` are high exactly when some set flag has its enable set. Enabling a source whose flag is already latched raises `irq`.
- R10: Reading address 12 returns the flag value and clears every flag in the same cycle. A flag event in that same cycle is kept, so it shows on the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sec_tick | input | 1 | One-cycle pulse, once per second |
| ref_tick | input | 1 | One-cycle pulse at the fast reference rate |
| addr | input | ADDR_W | Register address |
| wdata | input | 8 | Write data |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| rdata | output | 8 | Registered read data |
| irq | output | 1 | Level interrupt, high while the master flag is set |

## Verification
The bench builds the block with its defaults: both date alarm fields present, a day rollover at 0x31 and a 4-bit rate field. With the date fields present, the day and month compares and their don't-care codes can be reached, and so can the full carry chain from seconds into the month. A rate of 1 puts a periodic event on every reference tick. That lets the bench line up a reference tick with a flag read in one cycle, which is the collision R10 describes.

// File: rtl/rtc_irq_pkg.sv
package rtc_irq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_ADVANCE = 2'd1,
        ST_MATCH   = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic [7:0] mon;
        logic [7:0] day;
        logic [7:0] hour;
        logic [7:0] min;
        logic [7:0] sec;
    } bcd_time_t;

    // register addresses
    localparam int A_SEC   = 0;
    localparam int A_MIN   = 1;
    localparam int A_HOUR  = 2;
    localparam int A_DAY   = 3;
    localparam int A_MON   = 4;
    localparam int A_ASEC  = 5;
    localparam int A_AMIN  = 6;
    localparam int A_AHOUR = 7;
    localparam int A_ADAY  = 8;
    localparam int A_AMON  = 9;
    localparam int A_RATE  = 10;
    localparam int A_CTRL  = 11;
    localparam int A_FLAGS = 12;

    localparam int NUM_FIELDS = 5;
    localparam int NUM_SRC    = 3;  // 0 update, 1 alarm, 2 periodic
    localparam int B_SRC_LO   = 4;  // enables and flags share bits 4..6
    localparam int B_MASTER   = 7;
    localparam int B_H24      = 1;
    localparam int B_BIN      = 2;

    localparam logic [7:0] DONT_CARE = 8'hFF;

    // one BCD step: {wrapped, next value}
    function automatic logic [8:0] bcd_step(input logic [7:0] v,
                                            input logic [7:0] last,
                                            input logic [7:0] first);
        if (v == last)
            return {1'b1, first};
        else if (v[3:0] >= 4'd9)
            return {1'b0, v[7:4] + 4'd1, 4'd0};
        else
            return {1'b0, v[7:4], v[3:0] + 4'd1};
    endfunction

endpackage

// File: rtl/rtc_time_keeper.sv
module rtc_time_keeper
    import rtc_irq_pkg::*;
#(
    parameter logic [7:0] DAY_LAST = 8'h31
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  adv,
    input  logic [NUM_FIELDS-1:0] wr_field,
    input  logic [7:0]            wdata,
    output bcd_time_t             now
);

    bcd_time_t  nxt;
    logic [8:0] s_st, m_st, h_st, d_st, mo_st;

    always_comb begin
        s_st  = bcd_step(now.sec,  8'h59,    8'h00);
        m_st  = bcd_step(now.min,  8'h59,    8'h00);
        h_st  = bcd_step(now.hour, 8'h23,    8'h00);
        d_st  = bcd_step(now.day,  DAY_LAST, 8'h01);
        mo_st = bcd_step(now.mon,  8'h12,    8'h01);
        nxt     = now;
        nxt.sec = s_st[7:0];
        if (s_st[8]) begin
            nxt.min = m_st[7:0];
            if (m_st[8]) begin
                nxt.hour = h_st[7:0];
                if (h_st[8]) begin
                    nxt.day = d_st[7:0];
                    if (d_st[8])
                        nxt.mon = mo_st[7:0];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            now.sec  <= 8'h00;
            now.min  <= 8'h00;
            now.hour <= 8'h00;
            now.day  <= 8'h01;
            now.mon  <= 8'h01;
        end else if (|wr_field) begin
            if (wr_field[A_SEC])  now.sec  <= wdata;
            if (wr_field[A_MIN])  now.min  <= wdata;
            if (wr_field[A_HOUR]) now.hour <= wdata;
            if (wr_field[A_DAY])  now.day  <= wdata;
            if (wr_field[A_MON])  now.mon  <= wdata;
        end else if (adv) begin
            now <= nxt;
        end
    end

    // R4
    sec_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && wr_field == '0 && now.sec < 8'h60 && now.sec[3:0] <= 4'd9)
        |=> (now.sec < 8'h60 && now.sec[3:0] <= 4'd9));

endmodule

// File: rtl/rtc_alarm_cmp.sv
module rtc_alarm_cmp
    import rtc_irq_pkg::*;
#(
    parameter bit USE_DAY = 1'b1,
    parameter bit USE_MON = 1'b1
) (
    input  bcd_time_t now,
    input  bcd_time_t alm,
    output logic      hit
);

    logic sec_ok, min_ok, hour_ok, day_ok, mon_ok;

    assign sec_ok  = (alm.sec  == DONT_CARE) || (alm.sec  == now.sec);
    assign min_ok  = (alm.min  == DONT_CARE) || (alm.min  == now.min);
    assign hour_ok = (alm.hour == DONT_CARE) || (alm.hour == now.hour);

    generate
        if (USE_DAY) begin : g_day
            assign day_ok = (alm.day[5:0] == 6'd0) || (alm.day[5:0] == now.day[5:0]);
        end else begin : g_no_day
            assign day_ok = 1'b1;
        end
        if (USE_MON) begin : g_mon
            assign mon_ok = (alm.mon == 8'h00) || (alm.mon == DONT_CARE) ||
                            (alm.mon == now.mon);
        end else begin : g_no_mon
            assign mon_ok = 1'b1;
        end
    endgenerate

    assign hit = sec_ok && min_ok && hour_ok && day_ok && mon_ok;

endmodule

// File: rtl/rtc_rate_div.sv
module rtc_rate_div #(
    parameter int RATE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_tick,
    input  logic              restart,
    input  logic [RATE_W-1:0] rate,
    output logic              evt
);

    localparam int CNT_W = (1 << RATE_W) - 2;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] mask;

    always_comb begin
        for (int i = 0; i < CNT_W; i++)
            mask[i] = (i < int'(rate) - 1);
    end

    assign evt = ref_tick && (rate != '0) && ((cnt & mask) == mask);

    always_ff @(posedge clk) begin
        if (!rst_n || restart)
            cnt <= '0;
        else if (ref_tick)
            cnt <= cnt + 1'b1;
    end

    // R8
    restart_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !(evt && rate > 1));

endmodule

// File: rtl/rtc_irq_ctrl.sv
module rtc_irq_ctrl
    import rtc_irq_pkg::*;
#(
    parameter int                ADDR_W   = 4,
    parameter int                RATE_W   = 4,
    parameter bit                USE_DAY  = 1'b1,
    parameter bit                USE_MON  = 1'b1,
    parameter logic [7:0]        DAY_LAST = 8'h31,
    parameter logic [RATE_W-1:0] RATE_RST = RATE_W'(6)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sec_tick,
    input  logic              ref_tick,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    input  logic              wr_en,
    input  logic              rd_en,
    output logic [7:0]        rdata,
    output logic              irq
);

    localparam int SRC_UPD = 0;
    localparam int SRC_ALM = 1;
    localparam int SRC_PER = 2;

    seq_state_e state, state_nxt;
    logic adv, chk;

    bcd_time_t now, alm;
    logic [RATE_W-1:0]     rate;
    logic [NUM_SRC-1:0]    en, flg, flg_set;
    logic [NUM_FIELDS-1:0] wr_time;
    logic alm_hit, per_evt, rd_flags, rate_wr, master;
    logic [7:0] ctrl_view, flag_view, rd_mux;

    function automatic logic hit_addr(input logic [ADDR_W-1:0] a, input int idx);
        return a == ADDR_W'(idx);
    endfunction

    // ---------------- sequencer ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE:    if (sec_tick) state_nxt = ST_ADVANCE;
            ST_ADVANCE: state_nxt = ST_MATCH;
            ST_MATCH:   state_nxt = ST_IDLE;
            default:    state_nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        adv = 1'b0;
        chk = 1'b0;
        unique case (state)
            ST_IDLE:    ;
            ST_ADVANCE: adv = 1'b1;
            ST_MATCH:   chk = 1'b1;
            default:    ;
        endcase
    end

    // ---------------- time and compare ----------------
    generate
        for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_wr
            assign wr_time[i] = wr_en && hit_addr(addr, A_SEC + i);
        end
    endgenerate

    rtc_time_keeper #(.DAY_LAST(DAY_LAST)) u_time (
        .clk      (clk),
        .rst_n    (rst_n),
        .adv      (adv),
        .wr_field (wr_time),
        .wdata    (wdata),
        .now      (now)
    );

    rtc_alarm_cmp #(.USE_DAY(USE_DAY), .USE_MON(USE_MON)) u_cmp (
        .now (now),
        .alm (alm),
        .hit (alm_hit)
    );

    assign rate_wr = wr_en && hit_addr(addr, A_RATE);

    rtc_rate_div #(.RATE_W(RATE_W)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .ref_tick (ref_tick),
        .restart  (rate_wr),
        .rate     (rate),
        .evt      (per_evt)
    );

    // ---------------- host registers ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            alm  <= '0;
            rate <= RATE_RST;
            en   <= '0;
        end else if (wr_en) begin
            if (hit_addr(addr, A_ASEC))  alm.sec  <= wdata;
            if (hit_addr(addr, A_AMIN))  alm.min  <= wdata;
            if (hit_addr(addr, A_AHOUR)) alm.hour <= wdata;
            if (USE_DAY && hit_addr(addr, A_ADAY)) alm.day <= wdata;
            if (USE_MON && hit_addr(addr, A_AMON)) alm.mon <= wdata;
            if (hit_addr(addr, A_RATE))  rate <= wdata[RATE_W-1:0];
            if (hit_addr(addr, A_CTRL))  en   <= wdata[B_SRC_LO +: NUM_SRC];
        end
    end

    // ---------------- flags ----------------
    always_comb begin
        flg_set          = '0;
        flg_set[SRC_UPD] = chk;
        flg_set[SRC_ALM] = chk && alm_hit;
        flg_set[SRC_PER] = per_evt;
    end

    assign rd_flags = rd_en && hit_addr(addr, A_FLAGS);

    always_ff @(posedge clk) begin
        if (!rst_n)        flg <= '0;
        else if (rd_flags) flg <= flg_set;
        else               flg <= flg | flg_set;
    end

    assign master = |(flg & en);
    assign irq    = master;

    // ---------------- read path ----------------
    always_comb begin
        ctrl_view                       = '0;
        ctrl_view[B_SRC_LO +: NUM_SRC]  = en;
        ctrl_view[B_H24]                = 1'b1;
        ctrl_view[B_BIN]                = 1'b0;
        flag_view                       = '0;
        flag_view[B_SRC_LO +: NUM_SRC]  = flg;
        flag_view[B_MASTER]             = master;
    end

    always_comb begin
        case (addr)
            ADDR_W'(A_SEC):   rd_mux = now.sec;
            ADDR_W'(A_MIN):   rd_mux = now.min;
            ADDR_W'(A_HOUR):  rd_mux = now.hour;
            ADDR_W'(A_DAY):   rd_mux = now.day;
            ADDR_W'(A_MON):   rd_mux = now.mon;
            ADDR_W'(A_ASEC):  rd_mux = alm.sec;
            ADDR_W'(A_AMIN):  rd_mux = alm.min;
            ADDR_W'(A_AHOUR): rd_mux = alm.hour;
            ADDR_W'(A_ADAY):  rd_mux = alm.day;
            ADDR_W'(A_AMON):  rd_mux = alm.mon;
            ADDR_W'(A_RATE):  rd_mux = {{(8-RATE_W){1'b0}}, rate};
            ADDR_W'(A_CTRL):  rd_mux = ctrl_view;
            ADDR_W'(A_FLAGS): rd_mux = flag_view;
            default:          rd_mux = 8'h00;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)     rdata <= 8'h00;
        else if (rd_en) rdata <= rd_mux;
    end

    // R10
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_flags && flg_set == '0) |=> !irq);

    // R6
    alarm_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flg[SRC_ALM]) |-> ($past(state) == ST_MATCH && $past(alm_hit)));

    // R5
    seq_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_MATCH) |-> ($past(state) == ST_ADVANCE));

endmodule

// File: tb/test_rtc_irq_ctrl.sv
`timescale 1ns/1ps
module test_rtc_irq_ctrl;

    localparam logic [3:0] R_SEC = 4'd0,  R_MIN = 4'd1,  R_HOUR = 4'd2;
    localparam logic [3:0] R_DAY = 4'd3,  R_MON = 4'd4,  R_ASEC = 4'd5;
    localparam logic [3:0] R_AMIN = 4'd6, R_AHOUR = 4'd7, R_ADAY = 4'd8;
    localparam logic [3:0] R_AMON = 4'd9, R_RATE = 4'd10, R_CTRL = 4'd11;
    localparam logic [3:0] R_FLAGS = 4'd12;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sec_tick = 1'b0, ref_tick = 1'b0;
    logic [3:0] addr = '0;
    logic [7:0] wdata = '0;
    logic       wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0] rdata;
    logic       irq;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    rtc_irq_ctrl i_rtc_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .ref_tick(ref_tick),
        .addr(addr), .wdata(wdata), .wr_en(wr_en), .rd_en(rd_en),
        .rdata(rdata), .irq(irq)
    );

    // scoreboard
    logic [7:0] exp_q[$];
    string      tag_q[$];
    logic       rd_seen = 1'b0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: got %02h expected %02h", tag, act, exp);
        end
    endtask

    always @(posedge clk) rd_seen <= rd_en;

    always @(negedge clk) begin
        if (rd_seen) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "scoreboard underflow", int'(rdata), 0);
            end else begin
                logic [7:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(rdata === e, t, int'(rdata), int'(e));
            end
        end
    end

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, input logic [7:0] e, input string t);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        exp_q.push_back(e);
        tag_q.push_back(t);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic sec_pulse();
        @(negedge clk); sec_tick = 1'b1;
        @(negedge clk); sec_tick = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic ref_pulse();
        @(negedge clk); ref_tick = 1'b1;
        @(negedge clk); ref_tick = 1'b0;
    endtask

    task automatic check_irq(input logic e, input string t);
        @(negedge clk);
        check(irq === e, t, int'(irq), int'(e));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got 00 expected 01");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        check_irq(1'b0, "R1 irq low");
        rd(R_RATE,  8'h06, "R1 rate");
        rd(R_CTRL,  8'h02, "R1 ctrl");
        rd(R_FLAGS, 8'h00, "R1 flags");
        rd(R_SEC,   8'h00, "R1 sec");
        rd(R_DAY,   8'h01, "R1 day");
        rd(R_MON,   8'h01, "R1 mon");
        rd(R_ASEC,  8'h00, "R1 alarm sec");

        // R2 readback
        wr(R_ADAY, 8'hC5); rd(R_ADAY, 8'hC5, "R2 alarm day");
        wr(R_RATE, 8'hF3); rd(R_RATE, 8'h03, "R2 rate low bits");
        wr(R_RATE, 8'h06);
        wr(R_ADAY, 8'h00);

        // R3 control
        wr(R_CTRL, 8'hFF); rd(R_CTRL, 8'h72, "R3 all set");
        wr(R_CTRL, 8'h06); rd(R_CTRL, 8'h02, "R3 mode bits fixed");
        wr(R_CTRL, 8'h00);

        // R4 full carry chain
        wr(R_AHOUR, 8'h05);
        wr(R_SEC, 8'h59); wr(R_MIN, 8'h59); wr(R_HOUR, 8'h23);
        wr(R_DAY, 8'h31); wr(R_MON, 8'h12);
        sec_pulse();
        rd(R_SEC,  8'h00, "R4 sec wrap");
        rd(R_MIN,  8'h00, "R4 min wrap");
        rd(R_HOUR, 8'h00, "R4 hour wrap");
        rd(R_DAY,  8'h01, "R4 day wrap");
        rd(R_MON,  8'h01, "R4 month wrap");
        wr(R_SEC, 8'h09);
        sec_pulse();
        rd(R_SEC, 8'h10, "R4 BCD digit carry");

        // R5 update flag, masked; R10 clear
        rd(R_FLAGS, 8'h10, "R5 update flag");
        rd(R_FLAGS, 8'h00, "R10 cleared after read");

        // R6 alarm
        wr(R_HOUR, 8'h12); wr(R_MIN, 8'h34); wr(R_SEC, 8'h56);
        wr(R_ASEC, 8'h57); wr(R_AMIN, 8'hFF); wr(R_AHOUR, 8'hFF);
        wr(R_ADAY, 8'h00); wr(R_AMON, 8'h00);
        wr(R_CTRL, 8'h20);
        sec_pulse();
        check_irq(1'b1, "R6 alarm irq");
        rd(R_FLAGS, 8'hB0, "R6 alarm match");
        check_irq(1'b0, "R10 irq drops after read");
        sec_pulse();
        rd(R_FLAGS, 8'h10, "R6 alarm only once");
        rd(R_SEC, 8'h58, "R4 sec step");
        wr(R_ASEC, 8'hFF); wr(R_AMIN, 8'h34); wr(R_AHOUR, 8'h12);
        sec_pulse();
        rd(R_FLAGS, 8'hB0, "R6 sec dont-care match");
        wr(R_AHOUR, 8'h13);
        sec_pulse();
        rd(R_FLAGS, 8'h10, "R6 hour mismatch");

        // R7 date fields, masked alarm (R9 latch)
        wr(R_CTRL, 8'h00);
        wr(R_AMIN, 8'hFF); wr(R_AHOUR, 8'hFF);
        wr(R_ADAY, 8'hC5); wr(R_AMON, 8'h03);
        wr(R_DAY, 8'h05);  wr(R_MON, 8'h03);
        sec_pulse();
        check_irq(1'b0, "R9 masked no irq");
        rd(R_FLAGS, 8'h30, "R7 day low bits and month match");
        wr(R_AMON, 8'h04); sec_pulse();
        rd(R_FLAGS, 8'h10, "R7 month mismatch");
        wr(R_AMON, 8'hFF); sec_pulse();
        rd(R_FLAGS, 8'h30, "R7 month FF dont-care");
        wr(R_ADAY, 8'h06); sec_pulse();
        rd(R_FLAGS, 8'h10, "R7 day mismatch");
        wr(R_ADAY, 8'h00); sec_pulse();
        rd(R_FLAGS, 8'h30, "R7 day zero dont-care");

        // R8 periodic
        wr(R_RATE, 8'h03);
        wr(R_CTRL, 8'h40);
        repeat (3) ref_pulse();
        check_irq(1'b0, "R8 before period");
        rd(R_FLAGS, 8'h00, "R8 no early event");
        ref_pulse();
        check_irq(1'b1, "R8 periodic irq");
        rd(R_FLAGS, 8'hC0, "R8 fourth tick");
        wr(R_RATE, 8'h00);
        repeat (20) ref_pulse();
        rd(R_FLAGS, 8'h00, "R8 rate zero off");
        wr(R_RATE, 8'h01);
        ref_pulse();
        rd(R_FLAGS, 8'hC0, "R8 rate one each tick");

        // R10 same-cycle event kept
        ref_pulse();
        @(negedge clk);
        addr = R_FLAGS; rd_en = 1'b1; ref_tick = 1'b1;
        exp_q.push_back(8'hC0); tag_q.push_back("R10 read with event");
        @(negedge clk);
        rd_en = 1'b0; ref_tick = 1'b0;
        check(irq === 1'b1, "R10 kept event irq", int'(irq), 1);
        rd(R_FLAGS, 8'hC0, "R10 event kept");
        rd(R_FLAGS, 8'h00, "R10 then clear");

        // R9 enabling a latched flag
        wr(R_CTRL, 8'h00);
        wr(R_AHOUR, 8'h05);
        sec_pulse();
        check_irq(1'b0, "R9 masked update");
        wr(R_CTRL, 8'h10);
        check_irq(1'b1, "R9 enable after latch");
        rd(R_FLAGS, 8'h90, "R9 master with update");

        repeat (3) @(negedge clk);
        if (exp_q.size() != 0)
            check(1'b0, "scoreboard leftover", exp_q.size(), 0);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule